// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Walker

This block moves packets out of memory onto a byte stream by following a chain of descriptors. Each descriptor is a small record in memory. It holds a link to the next record, the address of a data buffer, a control word that gives the buffer length and the packet-boundary flags, a status word, and five application words. After a kick, the walker fetches each record over a single word-wide request/acknowledge memory port. When a record opens a packet, its application words go out on a separate 32-bit control stream. The buffer bytes then go out on an 8-bit data stream. The walker writes a completion status back into the record and moves on to the next one.

The walk ends in one of two ways. When the record just finished sits at the tail address, the walker raises `idle`. When it meets a record whose status already shows completion, it raises `halted`. Register decoding and interrupt logic sit outside the block. They drive `run`, `kick`, the current-pointer load and the tail pointer, and they watch `idle`, `halted`, `pkt_done` and `cur_ptr`.

Top module: `sg_tx_walker`

## Requirements
- R1: After reset `halted` is 1, `idle` is 0, `pkt_done` is 0, `cur_ptr` is 0, and `mem_req`, `dat_tvalid` and `ctl_tvalid` are all 0.
- R2: A walk starts only when `kick` is pulsed while `run` is 1 and the block is not walking. The kick also clears `idle`. A kick while `run` is 0 issues no memory request.
- R3: Bit 31 of the status word sits at byte offset 28 of a record. If that bit is already set when the record is fetched, the walker raises `halted` and stops. It emits no byte, writes nothing back and leaves `cur_ptr` unchanged.
- R4: When control bit 27 (start of packet) is set, the five words at record offsets 32, 36, 40, 44 and 48 go out in that order on the control stream. `ctl_tlast` is high on the fifth word, and all five words come before any data byte of that record.
- R5: The data stream carries exactly control[22:0] bytes, read from the buffer address at record offset 8. They start at that byte address, which need not be aligned, and run upward. Bytes within a memory word are ordered little-endian: byte k is bits 8k+7:8k.
- R6: When control bit 26 (end of packet) is set, `dat_tlast` is high on the record's last byte and on no other byte. `pkt_done` pulses for exactly one cycle for that record.
- R7: Each record that is consumed gets its status word, at offset 28, written as its length OR 0x80000000.
- R8: After the write-back, `cur_ptr` takes the next pointer from offset 0. If the record just processed was at `tail_ptr`, `idle` is raised and no further request is made.
- R9: While `dat_tready` or `ctl_tready` is low, the matching stream holds its valid, data and last signals unchanged. No byte or word is lost or repeated.
- R10: A record of length zero produces no data beat but is still written back and followed.
- R11: `mem_req` stays high with address, write enable and write data unchanged until `mem_ack`. Read data is taken in the acknowledge cycle.
- R12: A rising edge of `run` clears `halted` and `idle`. `cur_ld` loads `cur_ptr` only while the block is not walking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel enable level |
| kick | input | 1 | One-cycle start pulse (tail pointer updated) |
| cur_ld | input | 1 | Load `cur_in` into the current pointer |
| cur_in | input | AW | New current pointer |
| tail_ptr | input | AW | Address of the last record to process |
| cur_ptr | output | AW | Current record address |
| idle | output | 1 | Set when the tail record has been processed |
| halted | output | 1 | Set on a pre-completed record; set out of reset |
| pkt_done | output | 1 | One-cycle pulse per end-of-packet record |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | AW | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | AW | Read data |
| dat_tdata | output | 8 | Data stream byte |
| dat_tvalid | output | 1 | Data stream valid |
| dat_tlast | output | 1 | Last byte of packet |
| dat_tready | input | 1 | Data stream ready |
| ctl_tdata | output | AW | Control stream word |
| ctl_tvalid | output | 1 | Control stream valid |
| ctl_tlast | output | 1 | Last application word |
| ctl_tready | input | 1 | Control stream ready |

## Verification
Three-record chains are swept over every first-record length from 0 to 6. Each sweep pairs a start record and an end record around a flagless middle record, so zero-length records, records that end mid-word, and records that cross word boundaries all occur, with random stalls on both streams. Together these separate correct byte counts and lane order from dropped or repeated beats, and a last flag on the true end from one on a middle record. A single record with an unaligned buffer checks the starting byte lane. A tail placed mid-chain checks the idle stop against the pointer advance. A pre-completed record and a kick with the channel stopped check that nothing is read, written or emitted in those cases.

// File: rtl/sg_tx_walker.sv
module sg_tx_walker #(
  parameter int AW      = 32,
  parameter int LEN_W   = 23,
  parameter int APP_N   = 5,
  parameter int SOF_BIT = 27,
  parameter int EOF_BIT = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          kick,
  input  logic          cur_ld,
  input  logic [AW-1:0] cur_in,
  input  logic [AW-1:0] tail_ptr,
  output logic [AW-1:0] cur_ptr,
  output logic          idle,
  output logic          halted,
  output logic          pkt_done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic [7:0]    dat_tdata,
  output logic          dat_tvalid,
  output logic          dat_tlast,
  input  logic          dat_tready,
  output logic [AW-1:0] ctl_tdata,
  output logic          ctl_tvalid,
  output logic          ctl_tlast,
  input  logic          ctl_tready
);
  localparam int IDX_W   = (APP_N > 1) ? $clog2(APP_N) : 1;
  localparam int OFF_NXT = 0;
  localparam int OFF_BUF = 8;
  localparam int OFF_CTL = 24;
  localparam int OFF_STS = 28;
  localparam int OFF_APP = 32;

  typedef enum logic [3:0] {
    S_IDLE, S_STS, S_CTL, S_BUF, S_NXT, S_ARD, S_AOUT, S_DRD, S_DOUT, S_WB
  } st_t;

  st_t              st;
  logic [AW-1:0]    nxt, baddr, word;
  logic [LEN_W-1:0] len, rem;
  logic             sof, eof, run_q;
  logic [1:0]       bsel;
  logic [IDX_W-1:0] idx;

  assign mem_req = (st == S_STS) || (st == S_CTL) || (st == S_BUF) || (st == S_NXT) ||
                   (st == S_ARD) || (st == S_DRD) || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_wdata = AW'(len) | (AW'(1) << (AW-1));

  always_comb begin
    case (st)
      S_STS:   mem_addr = cur_ptr + AW'(OFF_STS);
      S_CTL:   mem_addr = cur_ptr + AW'(OFF_CTL);
      S_BUF:   mem_addr = cur_ptr + AW'(OFF_BUF);
      S_NXT:   mem_addr = cur_ptr + AW'(OFF_NXT);
      S_ARD:   mem_addr = cur_ptr + AW'(OFF_APP) + (AW'(idx) << 2);
      S_DRD:   mem_addr = baddr;
      S_WB:    mem_addr = cur_ptr + AW'(OFF_STS);
      default: mem_addr = cur_ptr;
    endcase
  end

  assign dat_tvalid = (st == S_DOUT);
  assign dat_tdata  = word[8*bsel +: 8];
  assign dat_tlast  = eof && (rem == LEN_W'(1));
  assign ctl_tvalid = (st == S_AOUT);
  assign ctl_tdata  = word;
  assign ctl_tlast  = (idx == IDX_W'(APP_N-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_ptr  <= '0;
      nxt      <= '0;
      baddr    <= '0;
      word     <= '0;
      len      <= '0;
      rem      <= '0;
      sof      <= 1'b0;
      eof      <= 1'b0;
      bsel     <= '0;
      idx      <= '0;
      run_q    <= 1'b0;
      idle     <= 1'b0;
      halted   <= 1'b1;
      pkt_done <= 1'b0;
    end else begin
      pkt_done <= 1'b0;
      run_q    <= run;
      if (run && !run_q) begin
        halted <= 1'b0;
        idle   <= 1'b0;
      end
      if (kick) idle <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cur_ld) cur_ptr <= cur_in;
          if (kick && run) st <= S_STS;
        end
        S_STS: if (mem_ack) begin
          if (mem_rdata[AW-1]) begin
            halted <= 1'b1;
            st     <= S_IDLE;
          end else st <= S_CTL;
        end
        S_CTL: if (mem_ack) begin
          len <= mem_rdata[LEN_W-1:0];
          rem <= mem_rdata[LEN_W-1:0];
          sof <= mem_rdata[SOF_BIT];
          eof <= mem_rdata[EOF_BIT];
          st  <= S_BUF;
        end
        S_BUF: if (mem_ack) begin
          baddr <= {mem_rdata[AW-1:2], 2'b00};
          bsel  <= mem_rdata[1:0];
          st    <= S_NXT;
        end
        S_NXT: if (mem_ack) begin
          nxt <= mem_rdata;
          idx <= '0;
          if (sof)                  st <= S_ARD;
          else if (rem == '0)       st <= S_WB;
          else                      st <= S_DRD;
        end
        S_ARD: if (mem_ack) begin
          word <= mem_rdata;
          st   <= S_AOUT;
        end
        S_AOUT: if (ctl_tready) begin
          if (idx == IDX_W'(APP_N-1)) st <= (rem == '0) ? S_WB : S_DRD;
          else begin
            idx <= idx + IDX_W'(1);
            st  <= S_ARD;
          end
        end
        S_DRD: if (mem_ack) begin
          word <= mem_rdata;
          st   <= S_DOUT;
        end
        S_DOUT: if (dat_tready) begin
          rem <= rem - LEN_W'(1);
          if (rem == LEN_W'(1)) st <= S_WB;
          else if (bsel == 2'd3) begin
            bsel  <= 2'd0;
            baddr <= baddr + AW'(4);
            st    <= S_DRD;
          end else bsel <= bsel + 2'd1;
        end
        S_WB: if (mem_ack) begin
          pkt_done <= eof;
          cur_ptr  <= nxt;
          if (cur_ptr == tail_ptr) begin
            idle <= 1'b1;
            st   <= S_IDLE;
          end else st <= S_STS;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sg_tx_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle,
  input logic          halted,
  input logic          pkt_done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic [7:0]    dat_tdata,
  input logic          dat_tvalid,
  input logic          dat_tlast,
  input logic          dat_tready,
  input logic [AW-1:0] ctl_tdata,
  input logic          ctl_tvalid,
  input logic          ctl_tlast,
  input logic          ctl_tready
);
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  p_dat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dat_tvalid && !dat_tready |=> dat_tvalid && $stable(dat_tdata) && $stable(dat_tlast));
  p_ctl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_tvalid && !ctl_tready |=> ctl_tvalid && $stable(ctl_tdata) && $stable(ctl_tlast));
  p_one_stream_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_tvalid && ctl_tvalid));
  p_wb_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[AW-1]);
  p_idle_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> !mem_req && !dat_tvalid && !ctl_tvalid);
  p_halt_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> !mem_req && !dat_tvalid);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);
endmodule

bind sg_tx_walker sg_tx_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .halted(halted), .pkt_done(pkt_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .dat_tdata(dat_tdata), .dat_tvalid(dat_tvalid),
  .dat_tlast(dat_tlast), .dat_tready(dat_tready), .ctl_tdata(ctl_tdata),
  .ctl_tvalid(ctl_tvalid), .ctl_tlast(ctl_tlast), .ctl_tready(ctl_tready)
);

// File: tb/sg_tx_walker_tb.sv
module sg_tx_walker_tb;
  logic        clk = 0, rst_n = 0, run = 0, kick = 0, cur_ld = 0;
  logic [31:0] cur_in = 0, tail_ptr = 0;
  logic [31:0] cur_ptr, mem_addr, mem_wdata, ctl_tdata;
  logic        idle, halted, pkt_done, mem_req, mem_we;
  logic        mem_ack = 0;
  logic [31:0] mem_rdata = 0;
  logic [7:0]  dat_tdata;
  logic        dat_tvalid, dat_tlast, ctl_tvalid, ctl_tlast;
  logic        dat_tready, ctl_tready;

  always #2.5 clk = ~clk;

  sg_tx_walker u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .kick(kick), .cur_ld(cur_ld), .cur_in(cur_in),
    .tail_ptr(tail_ptr), .cur_ptr(cur_ptr), .idle(idle), .halted(halted), .pkt_done(pkt_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dat_tdata(dat_tdata), .dat_tvalid(dat_tvalid),
    .dat_tlast(dat_tlast), .dat_tready(dat_tready), .ctl_tdata(ctl_tdata),
    .ctl_tvalid(ctl_tvalid), .ctl_tlast(ctl_tlast), .ctl_tready(ctl_tready));

  logic [31:0] mem [256];
  logic        bw = 0;
  logic [7:0]  ba = 0;
  logic [31:0] bd = 0;
  int          wr_n = 0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (bw) mem[ba] <= bd;
    else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        wr_n <= wr_n + 1;
      end
    end
  end

  logic [7:0]  dat_b [512];
  logic        dat_l [512];
  int          dat_c [512];
  logic [31:0] ctl_w [64];
  logic        ctl_l [64];
  int dat_n = 0, ctl_n = 0, done_n = 0, req_n = 0;
  logic [7:0] lfsr = 8'h5a;
  logic bp = 0;

  always @(negedge clk) begin
    logic rd, rc;
    rd = !bp || lfsr[0] || lfsr[1];
    rc = !bp || lfsr[2];
    dat_tready = rd;
    ctl_tready = rc;
    if (dat_tvalid && rd) begin
      dat_b[dat_n] = dat_tdata; dat_l[dat_n] = dat_tlast; dat_c[dat_n] = ctl_n;
      dat_n = dat_n + 1;
    end
    if (ctl_tvalid && rc) begin
      ctl_w[ctl_n] = ctl_tdata; ctl_l[ctl_n] = ctl_tlast;
      ctl_n = ctl_n + 1;
    end
    if (pkt_done) done_n = done_n + 1;
    if (mem_req) req_n = req_n + 1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  function automatic logic [31:0] appv(input int base, input int j);
    return {16'(base), 16'(j + 16'h00a0)};
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bw = 1; ba = 8'(a >> 2); bd = d;
    @(negedge clk);
    bw = 0;
  endtask

  task automatic set_desc(input int base, input int nx, input int bufa, input int len,
                          input bit s, input bit e, input logic [31:0] sts);
    wr(base + 0, 32'(nx));
    wr(base + 8, 32'(bufa));
    wr(base + 24, 32'(len) | (s ? 32'h0800_0000 : 0) | (e ? 32'h0400_0000 : 0));
    wr(base + 28, sts);
    for (int j = 0; j < 5; j++) wr(base + 32 + 4 * j, appv(base, j));
  endtask

  task automatic load_cur(input int a);
    @(negedge clk); cur_ld = 1; cur_in = 32'(a);
    @(negedge clk); cur_ld = 0;
  endtask

  task automatic do_kick();
    @(negedge clk); kick = 1;
    @(negedge clk); kick = 0;
  endtask

  task automatic wait_stop(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); #1;
      if ((idle || halted) && !mem_req && !dat_tvalid && !ctl_tvalid) begin ok = 1; break; end
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    int d0, c0, n0, w0, r0, exp_n, bad;
    int lens [3];
    int bases [3];
    bases[0] = 'h000; bases[1] = 'h040; bases[2] = 'h080;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1
    chk(halted == 1 && idle == 0 && pkt_done == 0 && cur_ptr == 0, "R1 flags",
        {halted, idle, pkt_done}, 3'b100);
    chk(!mem_req && !dat_tvalid && !ctl_tvalid, "R1 outputs quiet",
        {mem_req, dat_tvalid, ctl_tvalid}, 0);

    for (int a = 'h200; a < 'h400; a += 4)
      wr(a, {fb(a + 3), fb(a + 2), fb(a + 1), fb(a)});

    // R2: kick while stopped
    r0 = req_n;
    do_kick();
    repeat (20) @(negedge clk);
    #1 chk(req_n == r0, "R2 no request while run low", req_n - r0, 0);

    // R12: run rise clears halted
    @(negedge clk); run = 1;
    @(negedge clk); #1;
    chk(halted == 0 && idle == 0, "R12 run rise clears halted", halted, 0);

    // single record, unaligned buffer, SOF+EOF
    set_desc('h000, 'h040, 'h201, 5, 1, 1, 0);
    load_cur('h000); tail_ptr = 'h000;
    d0 = dat_n; c0 = ctl_n; n0 = done_n;
    do_kick();
    wait_stop(ok);
    chk(ok && idle, "R8 single record reaches idle", idle, 1);
    chk(ctl_n - c0 == 5, "R4 app word count", ctl_n - c0, 5);
    bad = 0;
    for (int j = 0; j < 5; j++)
      if (ctl_w[c0 + j] != appv('h000, j) || ctl_l[c0 + j] != (j == 4)) bad++;
    chk(bad == 0, "R4 app words and last", bad, 0);
    chk(dat_n - d0 == 5, "R5 byte count", dat_n - d0, 5);
    bad = 0;
    for (int k = 0; k < 5; k++) begin
      if (dat_b[d0 + k] != fb('h201 + k)) bad++;
      if (dat_l[d0 + k] != (k == 4)) bad++;
    end
    chk(bad == 0, "R5 R6 unaligned bytes and last", bad, 0);
    chk(dat_c[d0] == c0 + 5, "R4 app words before data", dat_c[d0], c0 + 5);
    chk(done_n - n0 == 1, "R6 pkt_done pulse", done_n - n0, 1);
    chk(mem[7] == 32'h8000_0005, "R7 status write-back", mem[7], 32'h8000_0005);
    chk(cur_ptr == 'h040, "R8 pointer advanced", cur_ptr, 'h040);

    // sweep of three-record chains with backpressure
    bp = 1;
    for (int L = 0; L < 7; L++) begin
      lens[0] = L; lens[1] = (L * 3) % 7; lens[2] = 2;
      for (int i = 0; i < 3; i++)
        set_desc(bases[i], bases[i] + 'h40, 'h200 + 'h40 * i, lens[i], i == 0, i == 2, 0);
      load_cur('h000); tail_ptr = 'h080;
      d0 = dat_n; c0 = ctl_n; n0 = done_n;
      do_kick();
      wait_stop(ok);
      exp_n = lens[0] + lens[1] + lens[2];
      chk(ok && idle && cur_ptr == 'h0c0, "R8 chain end pointer", cur_ptr, 'h0c0);
      chk(dat_n - d0 == exp_n, "R9 R10 chain byte count", dat_n - d0, exp_n);
      bad = 0;
      begin
        int p;
        p = d0;
        for (int i = 0; i < 3; i++)
          for (int k = 0; k < lens[i]; k++) begin
            if (dat_b[p] != fb('h200 + 'h40 * i + k)) bad++;
            if (dat_l[p] != (i == 2 && k == lens[2] - 1)) bad++;
            p++;
          end
      end
      chk(bad == 0, "R5 R6 R9 chain bytes and last", bad, 0);
      chk(ctl_n - c0 == 5 && dat_c[d0] == c0 + 5, "R4 chain app words", ctl_n - c0, 5);
      chk(done_n - n0 == 1, "R6 chain pkt_done", done_n - n0, 1);
      bad = 0;
      for (int i = 0; i < 3; i++)
        if (mem[(bases[i] + 28) >> 2] != (32'h8000_0000 | 32'(lens[i]))) bad++;
      chk(bad == 0, "R7 R10 chain write-backs", bad, 0);
    end
    bp = 0;

    // R3: pre-completed record
    set_desc('h000, 'h040, 'h200, 4, 1, 1, 32'h8000_0000);
    load_cur('h000); tail_ptr = 'h080;
    d0 = dat_n; c0 = ctl_n; w0 = wr_n;
    do_kick();
    wait_stop(ok);
    chk(ok && halted && !idle, "R3 halted raised", halted, 1);
    chk(dat_n == d0 && ctl_n == c0 && wr_n == w0, "R3 nothing emitted or written",
        (dat_n - d0) + (ctl_n - c0) + (wr_n - w0), 0);
    chk(cur_ptr == 'h000, "R3 pointer held", cur_ptr, 0);

    // R12: toggle run clears halted
    @(negedge clk); run = 0;
    @(negedge clk); run = 1;
    @(negedge clk); #1;
    chk(!halted, "R12 halted cleared by run", halted, 0);

    // R8: tail in the middle of a chain
    for (int i = 0; i < 3; i++)
      set_desc(bases[i], bases[i] + 'h40, 'h200 + 'h40 * i, 3, i == 0, i == 2, 0);
    load_cur('h000); tail_ptr = 'h040;
    d0 = dat_n; n0 = done_n;
    do_kick();
    wait_stop(ok);
    chk(ok && idle && cur_ptr == 'h080, "R8 mid-chain tail stop", cur_ptr, 'h080);
    chk(dat_n - d0 == 6 && done_n == n0, "R8 only two records sent", dat_n - d0, 6);
    chk(mem[('h080 + 28) >> 2] == 0, "R8 record past tail untouched", mem[('h080 + 28) >> 2], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule